// File: doc/BRIEF.md
# Multicycle Shared-Memory Datapath

This block is the data side of a 32-bit processor that runs each instruction over several clock cycles. A single memory holds both instructions and data, and a single ALU does both the program-counter arithmetic and the instruction's own arithmetic. The two are shared across cycles, and holding registers carry values from one step to the next. These registers are the instruction register, the memory data register, the two operand registers and the ALU result register.

An external sequencer drives every select and enable through the control inputs. It reads back the opcode of the held instruction and a zero flag taken from the live ALU result. The block contains the register file, the immediate extender, the operand and write-back muxes, the ALU with its local function decode, and the memory array. At reset the low words of the memory are loaded from a boot image parameter. The block also presents the program counter and the live ALU result, so that the state of the datapath can be seen.

Top module: `mcd_datapath`

## Requirements
- R1: In a cycle with synchronous active-low reset held low, the program counter, the instruction register, every holding register and every general register are cleared. Memory word i takes boot word i for i below BOOT_WORDS and zero above that.
- R2: The memory word address is bits [MEM_AW+1:2] of the program counter when `addr_from_alu` is 0, and of the ALU result register when it is 1. The read is combinational while `mem_rd` is high, and the memory data register captures it at every clock edge.
- R3: The instruction register loads the memory read data only at an edge where `ir_wr` is high, and otherwise holds. `opcode` is bits [31:26] of the instruction register.
- R4: ALU operand A is the program counter when `srca_is_a` is 0 and register A when it is 1. `srcb_sel` picks operand B: 00 gives register B, 01 gives the constant 4, 10 gives the sign-extended instruction bits [15:0], and 11 gives that value shifted left by 2.
- R5: `alu_mode` 00 forces add and 01 forces subtract. Mode 10 decodes instruction bits [3:0]: 0000 is add, 0010 is subtract, 0100 is AND, 0101 is OR, 1010 is signed set-less-than, and any other code is add. Mode 11 adds. `zero` is high exactly when the live result is 0.
- R6: The program counter loads when `pc_wr` is high, or when `pc_wr_cond` and `zero` are both high. Its next value is chosen by `pc_src`: 00 gives the live ALU result, 01 the ALU result register, and 10 gives {PC[31:28], instruction[25:0], 00}. When it does not load, it holds.
- R7: At an edge where `reg_wr` is high, the register selected by instruction bits [15:11] (when `dst_is_rd` is 1) or bits [20:16] (when it is 0) takes the memory data register (when `wb_from_mdr` is 1) or the ALU result register (when it is 0). Register 0 is never written.
- R8: At an edge where `mem_wr` is high, the addressed memory word takes operand register B.
- R9: Operand registers A and B capture the general registers addressed by instruction bits [25:21] and [20:16] at every edge. The ALU result register captures the live result at every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_wr | input | 1 | Unconditional program counter load |
| pc_wr_cond | input | 1 | Program counter load qualified by the zero flag |
| addr_from_alu | input | 1 | Memory address from the ALU result register (1) or the program counter (0) |
| mem_rd | input | 1 | Memory read enable |
| mem_wr | input | 1 | Memory write enable |
| ir_wr | input | 1 | Instruction register load |
| wb_from_mdr | input | 1 | Register write data from the memory data register (1) or the ALU result register (0) |
| dst_is_rd | input | 1 | Destination from bits [15:11] (1) or [20:16] (0) |
| reg_wr | input | 1 | Register file write enable |
| srca_is_a | input | 1 | ALU operand A select |
| srcb_sel | input | 2 | ALU operand B select |
| pc_src | input | 2 | Next program counter select |
| alu_mode | input | 2 | ALU mode (add, subtract, function decode) |
| opcode | output | 6 | Bits [31:26] of the instruction register |
| zero | output | 1 | Live ALU result equals zero |
| pc | output | 32 | Current program counter |
| alu_y | output | 32 | Live ALU result |

## Verification
The embedded properties check four things on every cycle. The program counter and the instruction register stay steady when not enabled. A jump or a taken branch lands on the right target one edge later. In subtract mode the zero flag matches operand equality. Any register or memory write shows up at its address on the next cycle. Only the bench scenarios can show the multi-step flow: a loaded value passing through the memory data register into the register file and on to a later computation, a store that is read back by a later load, branch decisions taken and not taken, and each function code of the local decode. Each of these is a sequence of several instructions that the bench steps through cycle by cycle.

// File: rtl/mcd_pkg.sv
// Package mcd_pkg: shared widths and encodings for the multicycle datapath.
// Assumes a 32-bit word and 5-bit register indices fixed by the instruction layout.
package mcd_pkg;
    localparam int WORD_W = 32;
    localparam int RIDX_W = 5;

    typedef enum logic [1:0] {
        SRCB_REG  = 2'b00,
        SRCB_FOUR = 2'b01,
        SRCB_IMM  = 2'b10,
        SRCB_IMM4 = 2'b11
    } srcb_e;

    typedef enum logic [1:0] {
        PCS_LIVE  = 2'b00,
        PCS_RESQ  = 2'b01,
        PCS_JUMP  = 2'b10,
        PCS_KEEP  = 2'b11
    } pcsrc_e;

    typedef enum logic [1:0] {
        AM_ADD   = 2'b00,
        AM_SUB   = 2'b01,
        AM_FUNCT = 2'b10,
        AM_SPARE = 2'b11
    } aluMode_e;

    typedef enum logic [2:0] {
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SLT
    } aluOp_e;
endpackage

// File: rtl/mcd_alu.sv
// Module mcd_alu: ALU with local function decode.
// The mode forces add or subtract. In function mode it decodes the low four
// function bits. Assumes the upper function bits are don't-care.
module mcd_alu
    import mcd_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [3:0]        funct_lo,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] y,
    output logic              zero
);
    aluOp_e op;

    // Local decode: mode plus function bits select the operation.
    always_comb begin
        case (aluMode_e'(mode))
            AM_SUB:   op = OP_SUB;
            AM_FUNCT: begin
                case (funct_lo)
                    4'b0010: op = OP_SUB;
                    4'b0100: op = OP_AND;
                    4'b0101: op = OP_OR;
                    4'b1010: op = OP_SLT;
                    default: op = OP_ADD;
                endcase
            end
            default:  op = OP_ADD;
        endcase
    end

    // Arithmetic and logic evaluation.
    always_comb begin
        case (op)
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_SLT:  y = {{(WORD_W-1){1'b0}}, $signed(a) < $signed(b)};
            default: y = a + b;
        endcase
    end

    // Zero flag from the live result.
    always_comb zero = (y == '0);
endmodule

// File: rtl/mcd_regfile.sv
// Module mcd_regfile: general register file, two combinational read ports,
// one synchronous write port. Index 0 is never written, so it reads zero.
module mcd_regfile #(
    parameter int AW = 5,
    parameter int W  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    localparam int NREG = 1 << AW;

    logic [W-1:0] regs [NREG];

    // Register storage: cleared by reset, written when enabled, index 0 skipped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // Combinational reads.
    always_comb begin
        rd1 = regs[ra1];
        rd2 = regs[ra2];
    end

    assert_reg_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (wa != '0)) |=> (regs[$past(wa)] == $past(wd)));
endmodule

// File: rtl/mcd_mem.sv
// Module mcd_mem: unified instruction/data word memory. The read is
// combinational and gated by the read enable; the write is synchronous.
// At reset, the low BOOT_WORDS words load from BOOT_IMAGE and the rest clear.
module mcd_mem #(
    parameter int AW         = 6,
    parameter int W          = 32,
    parameter int BOOT_WORDS = 16,
    parameter logic [BOOT_WORDS*W-1:0] BOOT_IMAGE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] idx,
    input  logic          rd,
    output logic [W-1:0]  rdata,
    input  logic          we,
    input  logic [W-1:0]  wdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        if (g < BOOT_WORDS) begin : g_boot
            // Boot word: image value at reset, write data otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n)                  mem[g] <= BOOT_IMAGE[g*W +: W];
                else if (we && (idx == g))   mem[g] <= wdata;
            end
        end else begin : g_plain
            // Plain word: zero at reset, write data otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n)                  mem[g] <= '0;
                else if (we && (idx == g))   mem[g] <= wdata;
            end
        end
    end

    // Gated combinational read.
    always_comb rdata = rd ? mem[idx] : '0;

    assert_mem_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/mcd_datapath.sv
// Module mcd_datapath: 32-bit multicycle datapath with one shared memory
// and one shared ALU. Holding registers between steps capture every cycle,
// except the instruction register, which loads only with ir_wr. All
// sequencing comes from an external controller through the control inputs.
module mcd_datapath
    import mcd_pkg::*;
#(
    parameter int MEM_AW     = 6,
    parameter int BOOT_WORDS = 16,
    parameter logic [BOOT_WORDS*32-1:0] BOOT_IMAGE = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pc_wr,
    input  logic        pc_wr_cond,
    input  logic        addr_from_alu,
    input  logic        mem_rd,
    input  logic        mem_wr,
    input  logic        ir_wr,
    input  logic        wb_from_mdr,
    input  logic        dst_is_rd,
    input  logic        reg_wr,
    input  logic        srca_is_a,
    input  logic [1:0]  srcb_sel,
    input  logic [1:0]  pc_src,
    input  logic [1:0]  alu_mode,
    output logic [5:0]  opcode,
    output logic        zero,
    output logic [31:0] pc,
    output logic [31:0] alu_y
);
    logic [WORD_W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, res_q;
    logic [WORD_W-1:0] mem_rdata, rf_rd1, rf_rd2;
    logic [WORD_W-1:0] imm_ext, srca, srcb, pc_next, wb_data;
    logic [MEM_AW-1:0] mem_idx;
    logic [RIDX_W-1:0] wr_idx;
    logic              pc_load;

    // Memory address: program counter or ALU result register.
    always_comb mem_idx = addr_from_alu ? res_q[MEM_AW+1:2] : pc_q[MEM_AW+1:2];

    // Immediate extension and ALU operand selection.
    always_comb begin
        imm_ext = {{(WORD_W-16){ir_q[15]}}, ir_q[15:0]};
        srca    = srca_is_a ? a_q : pc_q;
        case (srcb_e'(srcb_sel))
            SRCB_REG:  srcb = b_q;
            SRCB_FOUR: srcb = 32'd4;
            SRCB_IMM:  srcb = imm_ext;
            default:   srcb = {imm_ext[WORD_W-3:0], 2'b00};
        endcase
    end

    // Next program counter and its load condition.
    always_comb begin
        case (pcsrc_e'(pc_src))
            PCS_LIVE: pc_next = alu_y;
            PCS_RESQ: pc_next = res_q;
            PCS_JUMP: pc_next = {pc_q[31:28], ir_q[25:0], 2'b00};
            default:  pc_next = pc_q;
        endcase
        pc_load = pc_wr | (pc_wr_cond & zero);
    end

    // Register write destination and data.
    always_comb begin
        wr_idx  = dst_is_rd ? ir_q[15:11] : ir_q[20:16];
        wb_data = wb_from_mdr ? mdr_q : res_q;
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc_q <= '0;
        else if (pc_load) pc_q <= pc_next;
    end

    // Instruction register, gated by ir_wr.
    always_ff @(posedge clk) begin
        if (!rst_n)     ir_q <= '0;
        else if (ir_wr) ir_q <= mem_rdata;
    end

    // Ungated holding registers between steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
            res_q <= '0;
        end else begin
            mdr_q <= mem_rdata;
            a_q   <= rf_rd1;
            b_q   <= rf_rd2;
            res_q <= alu_y;
        end
    end

    mcd_mem #(
        .AW(MEM_AW), .W(WORD_W), .BOOT_WORDS(BOOT_WORDS), .BOOT_IMAGE(BOOT_IMAGE)
    ) u_mem (
        .clk(clk), .rst_n(rst_n), .idx(mem_idx), .rd(mem_rd),
        .rdata(mem_rdata), .we(mem_wr), .wdata(b_q)
    );

    mcd_regfile #(.AW(RIDX_W), .W(WORD_W)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .ra1(ir_q[25:21]), .ra2(ir_q[20:16]), .rd1(rf_rd1), .rd2(rf_rd2),
        .we(reg_wr), .wa(wr_idx), .wd(wb_data)
    );

    mcd_alu u_alu (
        .mode(alu_mode), .funct_lo(ir_q[3:0]), .a(srca), .b(srcb),
        .y(alu_y), .zero(zero)
    );

    // Outputs to the controller and observer.
    always_comb begin
        opcode = ir_q[31:26];
        pc     = pc_q;
    end

    assert_pc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_wr && !(pc_wr_cond && zero)) |=> $stable(pc_q));

    assert_pc_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr && pc_src == 2'b10) |=>
        (pc_q == {$past(pc_q[31:28]), $past(ir_q[25:0]), 2'b00}));

    assert_branch_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_wr && pc_wr_cond && zero && pc_src == 2'b01) |=> (pc_q == $past(res_q)));

    assert_ir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_wr |=> $stable(ir_q));

    assert_sub_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_mode == 2'b01) |-> (zero == (srca == srcb)));
endmodule

// File: tb/tb_mcd_datapath.sv
// Bench tb_mcd_datapath: acts as the sequencer. Step tasks drive the controls
// and push expected values into a scoreboard queue. A monitor compares them
// a quarter period after each falling edge.
module tb_mcd_datapath;
    localparam int CLK_P = 10;
    localparam logic [16*32-1:0] IMG = {
        32'hFFFFFFFD, 32'h00000005, 32'h10220005, 32'h0041282A,
        32'h00222825, 32'h00222824, 32'h00222822, 32'h00000000,
        32'h08000009, 32'h00000000, 32'h10640001, 32'h8C040040,
        32'hAC030040, 32'h00221820, 32'h8C02003C, 32'h8C010038
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic pc_wr, pc_wr_cond, addr_from_alu, mem_rd, mem_wr, ir_wr;
    logic wb_from_mdr, dst_is_rd, reg_wr, srca_is_a;
    logic [1:0] srcb_sel, pc_src, alu_mode;
    logic [5:0] opcode;
    logic zero;
    logic [31:0] pc, alu_y;

    mcd_datapath #(.MEM_AW(6), .BOOT_WORDS(16), .BOOT_IMAGE(IMG)) dut (
        .clk(clk), .rst_n(rst_n), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
        .addr_from_alu(addr_from_alu), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .ir_wr(ir_wr), .wb_from_mdr(wb_from_mdr), .dst_is_rd(dst_is_rd),
        .reg_wr(reg_wr), .srca_is_a(srca_is_a), .srcb_sel(srcb_sel),
        .pc_src(pc_src), .alu_mode(alu_mode), .opcode(opcode), .zero(zero),
        .pc(pc), .alu_y(alu_y)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        int          fld;   // 0 pc, 1 alu_y, 2 opcode, 3 zero
        logic [31:0] val;
        string       tag;
    } item_t;

    item_t sb[$];
    int n_checks = 0, n_fail = 0;
    logic [31:0] mpc = 0, mir = 0;
    bit done = 0;

    function automatic logic [31:0] img_word(input logic [31:0] addr);
        return IMG[addr[5:2]*32 +: 32];
    endfunction

    function automatic logic [31:0] sext(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic expect_v(input int fld, input logic [31:0] val, input string tag);
        item_t it;
        it.fld = fld; it.val = val; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: pops and compares everything queued for the current cycle.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.fld)
                    0: act = pc;
                    1: act = alu_y;
                    2: act = {26'd0, opcode};
                    default: act = {31'd0, zero};
                endcase
                n_checks++;
                if (act !== it.val) begin
                    n_fail++;
                    $display("FAIL %s field %0d actual %h expected %h", it.tag, it.fld, act, it.val);
                end
            end
        end
    end

    task automatic clr();
        pc_wr = 0; pc_wr_cond = 0; addr_from_alu = 0; mem_rd = 0; mem_wr = 0;
        ir_wr = 0; wb_from_mdr = 0; dst_is_rd = 0; reg_wr = 0; srca_is_a = 0;
        srcb_sel = 2'b00; pc_src = 2'b00; alu_mode = 2'b00;
    endtask

    task automatic fetch();
        @(negedge clk); clr();
        mem_rd = 1; ir_wr = 1; srcb_sel = 2'b01; pc_wr = 1;
        expect_v(0, mpc, "R6 pc at fetch");
        expect_v(1, mpc + 4, "R4 pc plus four");
        mir = img_word(mpc);
        mpc = mpc + 4;
    endtask

    task automatic decode();
        @(negedge clk); clr();
        srcb_sel = 2'b11;
        expect_v(2, {26'd0, mir[31:26]}, "R3 opcode after fetch");
        expect_v(0, mpc, "R6 pc holds in decode");
        expect_v(1, mpc + {sext(mir[15:0])[29:0], 2'b00}, "R4 branch target");
    endtask

    task automatic exec_addr(input logic [31:0] exp);
        @(negedge clk); clr();
        srca_is_a = 1; srcb_sel = 2'b10;
        expect_v(1, exp, "R9 R4 address A plus imm");
    endtask

    task automatic mem_read();
        @(negedge clk); clr();
        addr_from_alu = 1; mem_rd = 1;
    endtask

    task automatic wb_load();
        @(negedge clk); clr();
        reg_wr = 1; wb_from_mdr = 1;
        expect_v(2, {26'd0, mir[31:26]}, "R3 IR held across data read");
    endtask

    task automatic mem_store();
        @(negedge clk); clr();
        addr_from_alu = 1; mem_wr = 1;
    endtask

    task automatic exec_r(input logic [31:0] exp, input string tag);
        @(negedge clk); clr();
        srca_is_a = 1; alu_mode = 2'b10;
        expect_v(1, exp, tag);
    endtask

    task automatic wb_r();
        @(negedge clk); clr();
        reg_wr = 1; dst_is_rd = 1; srca_is_a = 1; alu_mode = 2'b10;
    endtask

    task automatic exec_beq(input bit taken);
        @(negedge clk); clr();
        srca_is_a = 1; alu_mode = 2'b01; pc_wr_cond = 1; pc_src = 2'b01;
        expect_v(3, {31'd0, taken}, "R5 R6 branch compare zero");
        if (taken) mpc = mpc + {sext(mir[15:0])[29:0], 2'b00};
    endtask

    task automatic exec_jump();
        @(negedge clk); clr();
        pc_wr = 1; pc_src = 2'b10;
        mpc = {mpc[31:28], mir[25:0], 2'b00};
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        clr();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state seen through the ports.
        @(negedge clk); clr();
        expect_v(0, 32'd0, "R1 pc after reset");
        expect_v(2, 32'd0, "R1 opcode after reset");
        expect_v(1, 32'd0, "R1 alu of cleared operands");
        expect_v(3, 32'd1, "R1 zero of cleared operands");
        // lw r1 and lw r2 from boot data (R2 address from ALU result register)
        fetch(); decode(); exec_addr(32'h38); mem_read(); wb_load();
        fetch(); decode(); exec_addr(32'h3C); mem_read(); wb_load();
        // add r3 = 5 + -3 (R7 loaded values reach the ALU)
        fetch(); decode(); exec_r(32'd2, "R5 R7 add of loaded regs"); wb_r();
        // sw r3 to word 16, then lw r4 back (R8)
        fetch(); decode(); exec_addr(32'h40); mem_store();
        fetch(); decode(); exec_addr(32'h40); mem_read(); wb_load();
        // beq r3,r4 taken: equal only if the store landed (R8)
        fetch(); decode(); exec_beq(1'b1);
        // jump at the branch target
        fetch(); decode(); exec_jump();
        // function decode cases (R5)
        fetch(); decode(); exec_r(32'd8, "R5 funct sub");
        fetch(); decode(); exec_r(32'd5, "R5 funct and");
        fetch(); decode(); exec_r(32'hFFFFFFFD, "R5 funct or");
        fetch(); decode(); exec_r(32'd1, "R5 funct signed slt");
        // beq r1,r2 not taken
        fetch(); decode(); exec_beq(1'b0);
        @(negedge clk); clr();
        expect_v(0, mpc, "R6 pc holds on untaken branch");
        repeat (2) @(negedge clk);
        #(CLK_P/2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule